// File: doc/BRIEF.md
# I2C Target Front-End with High-Speed Mode Tracking

This block is the bus-facing half of an I2C target. It samples the SCL and SDA lines with the system clock, cleans them up, finds START, repeated START and STOP conditions, and shifts bytes in and out MSB first. When the first byte after a START matches the target's 7-bit address, the block pulls SDA low in the ninth clock. SDA is driven only through an open-drain enable. After that, write bytes go to a register layer with a one-cycle valid strobe, and read bytes are taken from that layer.

The block also follows the bus speed mode. If the first byte after a START is the high-speed master code (`0000_1xxx`), the block leaves SDA released in the acknowledge slot. From the end of that clock it reports high-speed mode. Repeated STARTs keep the mode. Any STOP returns the block to standard/fast mode.

The address is `01101`, then a variant bit set by a parameter, then the level of the `addrPin` input. This lets up to four targets share one bus.

Top module: `i2c_tgt`

## Requirements
- R1: After reset, `sdaOe` is 0, `hsMode` is 0, and no strobe fires until the bus shows a START.
- R2: The first byte after a START is ACKed (`sdaOe`=1 during the ninth SCL high) when its upper seven bits equal {`01101`, VARIANT, `addrPin`}. Bit 0 is the direction: 0 means write, 1 means read.
- R3: On an address mismatch, SDA stays released in the ninth clock, and later bytes get no ACK and no `rxValid` until the next START.
- R4: In a write, each data byte appears on `rxData` MSB first together with a one-cycle `rxValid` pulse, and the block ACKs it.
- R5: In a read, the block samples `txData` with a one-cycle `txTake` pulse on the SCL fall that ends the previous acknowledge slot, and drives its bits MSB first (a 0 bit pulls SDA low).
- R6: A master ACK (SDA low in the ninth clock of a read byte) fetches the next byte. A master NACK ends the read: SDA stays released and nothing more is taken until a START.
- R7: A first byte of the form `00001xxx` is never ACKed. `hsMode` rises after the SCL fall that ends its ninth clock.
- R8: A repeated START does not change `hsMode`. An address following it starts a normal transfer in high-speed mode.
- R9: Every START gives a one-cycle `startStrobe`. Every STOP gives a one-cycle `stopStrobe` and clears `hsMode`.
- R10: A START seen in the middle of a byte discards the partial byte, and address reception restarts from bit 7.
- R11: `sdaOe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| addrPin | input | 1 | Address bit 0 select |
| txData | input | 8 | Next read byte from the register layer |
| sdaOe | output | 1 | Pull SDA low when 1 |
| hsMode | output | 1 | 1 = high-speed mode, 0 = standard/fast |
| rxData | output | 8 | Last received write byte |
| rxValid | output | 1 | One-cycle strobe, `rxData` valid |
| startStrobe | output | 1 | One-cycle strobe on START or repeated START |
| stopStrobe | output | 1 | One-cycle strobe on STOP |
| txTake | output | 1 | One-cycle strobe, `txData` sampled |

## Verification
A control state that drifts out of step with the bit counter shows at the ports within the next byte. The ACK moves off the ninth clock, data bytes arrive shifted, or a mismatched address starts acknowledging. A wrong speed flag shows on `hsMode` at once: right after the master-code acknowledge slot, across a repeated START, or after a STOP. A read path that loads or shifts at the wrong edge returns bytes whose bits are rotated or repeated, and a missed master NACK keeps pulling SDA low on the following clocks.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK, ST_MCODE, ST_WRITE, ST_READ, ST_RDHOLD, ST_MACK
  } tgtState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic cntEn;
    logic loadTx;
    logic shiftTx;
  } dpCmd_t;

  // bus events from datapath to control
  typedef struct packed {
    logic sclLvl;
    logic sdaLvl;
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
    logic byteRdy;
  } busEv_t;
endpackage

// File: rtl/i2c_tgt_dp.sv
module i2c_tgt_dp
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] txData,
  input  dpCmd_t            cmd,
  output busEv_t            ev,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txBit
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic [2:0] sclWin, sdaWin;
  logic sclF, sdaF, sclP, sdaP;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] rxSh, txSh;
  logic byteRdyQ;

  function automatic logic maj3(input logic [2:0] w);
    return (w[0] & w[1]) | (w[0] & w[2]) | (w[1] & w[2]);
  endfunction

  // synchroniser chains, length picked by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= sclIn;
          sdaSync <= sdaIn;
        end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
          sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
        end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclWin <= '1;
      sdaWin <= '1;
      sclF   <= 1'b1;
      sdaF   <= 1'b1;
      sclP   <= 1'b1;
      sdaP   <= 1'b1;
    end else begin
      sclWin <= {sclWin[1:0], sclSync[SYNC_STAGES-1]};
      sdaWin <= {sdaWin[1:0], sdaSync[SYNC_STAGES-1]};
      sclF   <= maj3(sclWin);
      sdaF   <= maj3(sdaWin);
      sclP   <= sclF;
      sdaP   <= sdaF;
    end
  end

  always_comb begin
    ev.sclLvl   = sclF;
    ev.sdaLvl   = sdaF;
    ev.sclRise  = sclF & ~sclP;
    ev.sclFall  = ~sclF & sclP;
    ev.startDet = sclF & sclP & sdaP & ~sdaF;
    ev.stopDet  = sclF & sclP & ~sdaP & sdaF;
    ev.byteRdy  = byteRdyQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      rxSh     <= '0;
      txSh     <= '1;
      byteRdyQ <= 1'b0;
    end else begin
      byteRdyQ <= 1'b0;
      if (ev.sclRise) rxSh <= {rxSh[BYTE_W-2:0], sdaF};
      if (cmd.clrCnt) bitCnt <= '0;
      else if (cmd.cntEn && ev.sclRise) begin
        bitCnt   <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
        byteRdyQ <= (bitCnt == LAST_BIT);
      end
      if (cmd.loadTx) txSh <= txData;
      else if (cmd.shiftTx) txSh <= {txSh[BYTE_W-2:0], 1'b1};
    end
  end

  assign rxByte = rxSh;
  assign txBit  = txSh[BYTE_W-1];

  // R10: a START always restarts the bit count
  a_r10_start_restarts_byte: assert property (@(posedge clk) disable iff (!rstN)
    ev.startDet |=> (bitCnt == '0))
    else $error("R10 bit counter not cleared by START");
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [4:0] ADDR_HI = 5'b01101,
  parameter logic       VARIANT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEv_t            ev,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txBit,
  input  logic              addrPin,
  output dpCmd_t            cmd,
  output logic              sdaOe,
  output logic              hsMode,
  output logic              rxValid,
  output logic              startStrobe,
  output logic              stopStrobe,
  output logic              txTake
);
  localparam logic [4:0] MCODE_HI = 5'b00001;

  tgtState_e state;
  logic half, rnwQ, nackQ, ackOnQ, hsQ;
  logic [6:0] myAddr;
  logic busCond, readPhase;

  assign myAddr    = {ADDR_HI, VARIANT, addrPin};
  assign busCond   = ev.startDet | ev.stopDet;
  assign readPhase = (state == ST_READ) || (state == ST_RDHOLD);

  always_comb begin
    cmd.clrCnt  = busCond;
    cmd.cntEn   = (state == ST_ADDR) || (state == ST_WRITE) || (state == ST_READ);
    cmd.loadTx  = !busCond && ev.sclFall &&
                  (((state == ST_ACK) && half && rnwQ) || ((state == ST_MACK) && !nackQ));
    cmd.shiftTx = !busCond && ev.sclFall && (state == ST_READ);
  end

  assign txTake = cmd.loadTx;
  assign sdaOe  = readPhase ? ~txBit : ackOnQ;
  assign hsMode = hsQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      half        <= 1'b0;
      rnwQ        <= 1'b0;
      nackQ       <= 1'b0;
      ackOnQ      <= 1'b0;
      hsQ         <= 1'b0;
      rxValid     <= 1'b0;
      startStrobe <= 1'b0;
      stopStrobe  <= 1'b0;
    end else begin
      rxValid     <= 1'b0;
      startStrobe <= 1'b0;
      stopStrobe  <= 1'b0;
      if (ev.stopDet) begin
        state      <= ST_IDLE;
        half       <= 1'b0;
        ackOnQ     <= 1'b0;
        hsQ        <= 1'b0;
        stopStrobe <= 1'b1;
      end else if (ev.startDet) begin
        state       <= ST_ADDR;
        half        <= 1'b0;
        ackOnQ      <= 1'b0;
        startStrobe <= 1'b1;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR:
            if (ev.byteRdy) begin
              half <= 1'b0;
              if (rxByte[7:3] == MCODE_HI) state <= ST_MCODE;
              else if (rxByte[7:1] == myAddr) begin
                state <= ST_ACK;
                rnwQ  <= rxByte[0];
              end else state <= ST_IDLE;
            end
          ST_ACK:
            if (ev.sclFall) begin
              if (!half) begin
                half   <= 1'b1;
                ackOnQ <= 1'b1;
              end else begin
                half   <= 1'b0;
                ackOnQ <= 1'b0;
                state  <= rnwQ ? ST_READ : ST_WRITE;
              end
            end
          ST_MCODE:
            if (ev.sclFall) begin
              if (!half) half <= 1'b1;
              else begin
                half  <= 1'b0;
                hsQ   <= 1'b1;
                state <= ST_IDLE;
              end
            end
          ST_WRITE:
            if (ev.byteRdy) begin
              rxValid <= 1'b1;
              half    <= 1'b0;
              state   <= ST_ACK;
            end
          ST_READ:
            if (ev.byteRdy) state <= ST_RDHOLD;
          ST_RDHOLD:
            if (ev.sclFall) begin
              nackQ <= 1'b0;
              state <= ST_MACK;
            end
          ST_MACK: begin
            if (ev.sclRise) nackQ <= ev.sdaLvl;
            if (ev.sclFall) state <= nackQ ? ST_IDLE : ST_READ;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  a_r9_stop_clears_hs: assert property (@(posedge clk) disable iff (!rstN)
    ev.stopDet |=> !hsMode)
    else $error("R9 hsMode survived STOP");

  a_r8_restart_keeps_hs: assert property (@(posedge clk) disable iff (!rstN)
    (ev.startDet && !ev.stopDet) |=> (hsMode == $past(hsMode)))
    else $error("R8 hsMode changed on repeated START");

  a_r7_mcode_never_pulls: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MCODE) |-> !sdaOe)
    else $error("R7 SDA pulled after master code");

  a_r11_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !ev.sclLvl)
    else $error("R11 sdaOe changed while SCL high");
endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt
  import i2c_tgt_pkg::*;
#(
  parameter logic VARIANT     = 1'b0,
  parameter int   SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic        addrPin,
  input  logic [7:0]  txData,
  output logic        sdaOe,
  output logic        hsMode,
  output logic [7:0]  rxData,
  output logic        rxValid,
  output logic        startStrobe,
  output logic        stopStrobe,
  output logic        txTake
);
  dpCmd_t cmd;
  busEv_t ev;
  logic [BYTE_W-1:0] rxByte;
  logic txBit;

  i2c_tgt_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .txData(txData),
    .cmd(cmd), .ev(ev), .rxByte(rxByte), .txBit(txBit)
  );

  i2c_tgt_ctrl #(.ADDR_HI(5'b01101), .VARIANT(VARIANT)) u_ctrl (
    .clk(clk), .rstN(rstN), .ev(ev), .rxByte(rxByte), .txBit(txBit),
    .addrPin(addrPin), .cmd(cmd), .sdaOe(sdaOe), .hsMode(hsMode),
    .rxValid(rxValid), .startStrobe(startStrobe), .stopStrobe(stopStrobe),
    .txTake(txTake)
  );

  assign rxData = rxByte;
endmodule

// File: tb/i2c_tgt_tb.sv
module i2c_tgt_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 16;
  localparam int QTR = 4;
  localparam logic VAR_BIT = 1'b1;

  logic clk = 0, rstN = 0, sclBus = 1, sdaM = 1, addrPin = 0;
  logic [7:0] txData = 8'h96;
  logic sdaOe, hsMode, rxValid, startStrobe, stopStrobe, txTake;
  logic [7:0] rxData;
  wire sdaLine = sdaM & ~sdaOe;

  int nChecks = 0, nFail = 0, rxCnt = 0, startCnt = 0, stopCnt = 0, takeCnt = 0, oeViol = 0;
  logic [7:0] rxLog [0:15];
  logic flipNext = 0, prevOe = 0, done = 0;

  i2c_tgt #(.VARIANT(VAR_BIT)) u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclBus), .sdaIn(sdaLine), .addrPin(addrPin),
    .txData(txData), .sdaOe(sdaOe), .hsMode(hsMode), .rxData(rxData),
    .rxValid(rxValid), .startStrobe(startStrobe), .stopStrobe(stopStrobe),
    .txTake(txTake)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (flipNext) begin txData = ~txData; flipNext = 0; end
    if (txTake) begin takeCnt++; flipNext = 1; end
    if (rxValid) begin rxLog[rxCnt % 16] = rxData; rxCnt++; end
    if (startStrobe) startCnt++;
    if (stopStrobe) stopCnt++;
    if (sdaOe != prevOe && sclBus) oeViol++;
    prevOe = sdaOe;
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busStart();
    waitClk(QTR); sdaM = 1; waitClk(HALF);
    sclBus = 1; waitClk(HALF);
    sdaM = 0; waitClk(HALF);
    sclBus = 0;
  endtask

  task automatic busStop();
    waitClk(QTR); sdaM = 0; waitClk(HALF);
    sclBus = 1; waitClk(HALF);
    sdaM = 1; waitClk(HALF);
  endtask

  task automatic sendBit(input logic b);
    waitClk(QTR); sdaM = b; waitClk(HALF - QTR);
    sclBus = 1; waitClk(HALF);
    sclBus = 0;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    waitClk(QTR); sdaM = 1; waitClk(HALF - QTR);
    sclBus = 1; waitClk(HALF/2);
    ack = (sdaLine == 1'b0);
    waitClk(HALF/2);
    sclBus = 0;
  endtask

  task automatic readByte(input logic mAck, output logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      waitClk(QTR); sdaM = 1; waitClk(HALF - QTR);
      sclBus = 1; waitClk(HALF/2);
      d = {d[6:0], sdaLine};
      waitClk(HALF/2);
      sclBus = 0;
    end
    sendBit(~mAck);
  endtask

  task automatic tReset();
    check(sdaOe == 0, "R1 sdaOe after reset", sdaOe, 0);
    check(hsMode == 0, "R1 hsMode after reset", hsMode, 0);
    check(rxCnt == 0 && startCnt == 0 && stopCnt == 0 && takeCnt == 0,
          "R1 strobes quiet", rxCnt + startCnt + stopCnt + takeCnt, 0);
  endtask

  task automatic tWrite();
    logic ack; int r0 = rxCnt, s0 = startCnt, p0 = stopCnt;
    busStart();
    sendByte({5'b01101, VAR_BIT, 1'b0, 1'b0}, ack);
    check(ack, "R2 address write ACK", ack, 1);
    sendByte(8'hA5, ack); check(ack, "R4 data byte 1 ACK", ack, 1);
    sendByte(8'h3C, ack); check(ack, "R4 data byte 2 ACK", ack, 1);
    busStop(); waitClk(10);
    check(rxCnt - r0 == 2, "R4 rxValid count", rxCnt - r0, 2);
    check(rxLog[r0 % 16] == 8'hA5, "R4 byte 1 value", rxLog[r0 % 16], 8'hA5);
    check(rxLog[(r0 + 1) % 16] == 8'h3C, "R4 byte 2 value", rxLog[(r0 + 1) % 16], 8'h3C);
    check(startCnt - s0 == 1, "R9 startStrobe count", startCnt - s0, 1);
    check(stopCnt - p0 == 1, "R9 stopStrobe count", stopCnt - p0, 1);
  endtask

  task automatic tMismatch();
    logic ack; int r0 = rxCnt;
    busStart();
    sendByte({5'b01101, ~VAR_BIT, 1'b0, 1'b0}, ack);
    check(!ack, "R3 mismatch not ACKed", ack, 0);
    sendByte(8'h55, ack);
    check(!ack, "R3 later byte not ACKed", ack, 0);
    busStop(); waitClk(10);
    check(rxCnt == r0, "R3 no rxValid", rxCnt - r0, 0);
  endtask

  task automatic tPin();
    logic ack;
    addrPin = 1;
    busStart(); sendByte({5'b01101, VAR_BIT, 1'b1, 1'b0}, ack); busStop();
    check(ack, "R2 pin-high address ACK", ack, 1);
    busStart(); sendByte({5'b01101, VAR_BIT, 1'b0, 1'b0}, ack); busStop();
    check(!ack, "R2 pin-low address refused", ack, 0);
    addrPin = 0;
  endtask

  task automatic tRead();
    logic ack; logic [7:0] d; int t0;
    waitClk(2); txData = 8'h96; t0 = takeCnt;
    busStart();
    sendByte({5'b01101, VAR_BIT, 1'b0, 1'b1}, ack);
    check(ack, "R2 address read ACK", ack, 1);
    readByte(1'b1, d); check(d == 8'h96, "R5 first read byte", d, 8'h96);
    readByte(1'b0, d); check(d == 8'h69, "R6 byte after master ACK", d, 8'h69);
    check(takeCnt - t0 == 2, "R5 txTake count", takeCnt - t0, 2);
    readByte(1'b1, d); check(d == 8'hFF, "R6 released after NACK", d, 8'hFF);
    check(takeCnt - t0 == 2, "R6 no take after NACK", takeCnt - t0, 2);
    busStop(); waitClk(10);
  endtask

  task automatic tHs();
    logic ack; int r0 = rxCnt;
    busStart();
    sendByte(8'h0D, ack);
    check(!ack, "R7 master code NACKed", ack, 0);
    waitClk(10);
    check(hsMode == 1, "R7 hsMode set", hsMode, 1);
    busStart(); waitClk(4);
    check(hsMode == 1, "R8 hsMode kept over Sr", hsMode, 1);
    sendByte({5'b01101, VAR_BIT, 1'b0, 1'b0}, ack);
    check(ack, "R8 address ACK in high-speed", ack, 1);
    sendByte(8'hC3, ack);
    check(ack && rxLog[r0 % 16] == 8'hC3, "R8 write in high-speed", rxLog[r0 % 16], 8'hC3);
    busStart(); waitClk(4);
    check(hsMode == 1, "R8 hsMode kept over second Sr", hsMode, 1);
    busStop(); waitClk(10);
    check(hsMode == 0, "R9 STOP clears hsMode", hsMode, 0);
  endtask

  task automatic tAbort();
    logic ack; int r0 = rxCnt;
    busStart();
    sendBit(1); sendBit(0); sendBit(1); sendBit(1);
    busStart();
    sendByte({5'b01101, VAR_BIT, 1'b0, 1'b0}, ack);
    check(ack, "R10 address after aborted byte ACKed", ack, 1);
    sendByte(8'h7E, ack);
    busStop(); waitClk(10);
    check(rxCnt - r0 == 1 && rxLog[r0 % 16] == 8'h7E, "R10 byte after abort",
          rxLog[r0 % 16], 8'h7E);
  endtask

  initial begin
    waitClk(5); rstN = 1; waitClk(5);
    tReset();
    tWrite();
    tMismatch();
    tPin();
    tRead();
    tHs();
    tAbort();
    check(oeViol == 0, "R11 sdaOe steady while SCL high", oeViol, 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule